// File: doc/BRIEF.md
# Daisy-Chain Bus Arbiter

This block decides which of several potential bus masters may drive a shared bus. Every master's request is merged into one common request line. When that line is high, a central controller raises a single grant. The grant enters a chain of per-device cells at the highest-priority position and ripples toward the lowest. A cell whose device is requesting absorbs the grant and does not pass it on. A cell whose device is idle forwards the grant unchanged. Priority therefore comes only from a device's position in the chain.

The device that absorbs the grant becomes the owner and holds the bus until it pulses the shared release line. The controller then withdraws the grant for at least one full cycle before it arbitrates again. No scheme for fairness exists: a low-priority device can wait for ever while higher-priority devices keep requesting.

Top module: `chain_arb_top`

## Requirements
- R1: After reset `grant_o`, `busy_o` and every bit of `owned_o` are low.
- R2: The request line is the OR of all bits of `req_i`. From idle, any nonzero `req_i` drives `grant_o` high one clock edge later.
- R3: The owner is the requesting device with the lowest index (bit 0 is the highest priority). Its `owned_o` bit rises at the edge after `grant_o` went high.
- R4: A device never owns the bus unless the grant reached it, which means no lower-index device was requesting at that edge.
- R5: At most one bit of `owned_o` is high in any cycle.
- R6: `busy_o` rises one edge after an owner appears. `grant_o` is low whenever any device owns the bus or `busy_o` is high.
- R7: `release_i` high while `busy_o` is high clears the owner and `busy_o` at the next edge. `grant_o` then stays low for at least that following cycle.
- R8: `release_i` has no effect unless `busy_o` is high. It neither clears an owner nor changes `grant_o`.
- R9: If all requests are withdrawn while the grant is raised and no device has taken it, the block returns to idle with no owner.
- R10: While device 0 keeps requesting, device N_DEV-1 never becomes owner.
- R11: The owner keeps ownership during `busy_o` even if its own request drops, until `release_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | N_DEV | Per-device bus request, bit 0 highest priority |
| release_i | input | 1 | Shared release line from the current owner |
| grant_o | output | 1 | Grant entering the head of the chain |
| owned_o | output | N_DEV | Per-device ownership flag |
| busy_o | output | 1 | Bus held by an owner |

## Verification
The bench goes through every nonzero request pattern of a four-device chain. For each one it computes the lowest set bit and expects exactly that device to win. A chain that let the grant leak past a requester would show two owners or the wrong one. The bench pulses release outside the busy phase, and a design that honoured it there would lose its owner early or re-grant without a gap. It also withdraws requests just after the grant is raised, drops the owner's request mid-transfer, and holds device 0 requesting across repeated grants. Those cases catch a controller that hangs in the granting state, a cell that gives up ownership early, and a chain that hands the bus to a lower device for fairness.

// File: rtl/chain_arb_pkg.sv
package chain_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GRANT = 2'd1,
    ST_BUSY  = 2'd2
  } arb_state_e;
endpackage

// File: rtl/chain_arb_cell.sv
module chain_arb_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic grant_i,
  input  logic release_i,
  input  logic busy_i,
  output logic grant_o,
  output logic owned_o
);
  logic take;
  logic owned_q;

  assign take    = grant_i & req_i;
  assign grant_o = grant_i & ~req_i;  // absorb when requesting
  assign owned_o = owned_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   owned_q <= 1'b0;
    else if (take)                 owned_q <= 1'b1;
    else if (busy_i && release_i)  owned_q <= 1'b0;
  end
endmodule

// File: rtl/chain_arb_fsm.sv
module chain_arb_fsm
  import chain_arb_pkg::*;
#(
  parameter int N_DEV = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_any_i,
  input  logic             release_i,
  input  logic [N_DEV-1:0] owned_i,
  output logic             grant_o,
  output logic             busy_o,
  output arb_state_e       state_o
);
  arb_state_e state_q, state_d;
  logic any_owned, one_owned;

  assign any_owned = |owned_i;
  assign one_owned = any_owned && ((owned_i & (owned_i - 1'b1)) == '0);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_any_i) state_d = ST_GRANT;
      ST_GRANT: begin
        if (one_owned)                      state_d = ST_BUSY;
        else if (!any_owned && !req_any_i)  state_d = ST_IDLE;
      end
      ST_BUSY:  if (release_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // grant withdrawn as soon as a cell has taken it
  assign grant_o = (state_q == ST_GRANT) && !any_owned;
  assign busy_o  = (state_q == ST_BUSY);
  assign state_o = state_q;
endmodule

// File: rtl/chain_arb_top.sv
module chain_arb_top
  import chain_arb_pkg::*;
#(
  parameter int N_DEV = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_DEV-1:0] req_i,
  input  logic             release_i,
  output logic             grant_o,
  output logic [N_DEV-1:0] owned_o,
  output logic             busy_o
);
  logic [N_DEV:0]   chain;
  logic             req_line;
  logic             head_grant;
  logic             busy;
  arb_state_e       state;

  assign req_line = |req_i;  // wired-OR request line

  chain_arb_fsm #(.N_DEV(N_DEV)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_any_i (req_line),
    .release_i (release_i),
    .owned_i   (owned_o),
    .grant_o   (head_grant),
    .busy_o    (busy),
    .state_o   (state)
  );

  assign chain[0] = head_grant;

  for (genvar g = 0; g < N_DEV; g++) begin : g_cell
    chain_arb_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_i     (req_i[g]),
      .grant_i   (chain[g]),
      .release_i (release_i),
      .busy_i    (busy),
      .grant_o   (chain[g+1]),
      .owned_o   (owned_o[g])
    );
  end

  assign grant_o = head_grant;
  assign busy_o  = busy;
endmodule

// File: rtl/chain_arb_chk.sv
module chain_arb_chk #(
  parameter int N_DEV = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_DEV-1:0] req_i,
  input logic             release_i,
  input logic             grant_o,
  input logic [N_DEV-1:0] owned_o,
  input logic             busy_o
);
  logic [N_DEV-1:0] owned_below;
  assign owned_below = owned_o - 1'b1;

  p_one_owner_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(owned_o));

  p_busy_no_grant_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o || owned_o != '0) |-> !grant_o);

  p_busy_follows_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owned_o != '0 && !busy_o && !release_i) |=> busy_o);

  p_release_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && release_i) |=> (owned_o == '0 && !busy_o && !grant_o));

  p_grant_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !grant_o);

  p_owner_holds_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !release_i) |=> $stable(owned_o));

  // new owner was requesting and no higher-priority device was
  p_priority_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && req_i != '0) |=>
      (((owned_o & $past(req_i)) != '0) && (($past(req_i) & owned_below) == '0)));
endmodule

bind chain_arb_top chain_arb_chk #(.N_DEV(N_DEV)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .release_i (release_i),
  .grant_o   (grant_o),
  .owned_o   (owned_o),
  .busy_o    (busy_o)
);

// File: tb/chain_arb_top_tb.sv
module chain_arb_top_tb;
  localparam int N = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] req_i = '0;
  logic         release_i = 1'b0;
  logic         grant_o;
  logic [N-1:0] owned_o;
  logic         busy_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  chain_arb_top #(.N_DEV(N)) u_dut (.*);

  always #4 clk_i = ~clk_i;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // per-cycle exclusivity check away from the edge
  always @(negedge clk_i) if (rst_ni && !done) begin
    n_chk++;
    if ((owned_o & (owned_o - 1'b1)) != '0) begin
      n_err++;
      $display("FAIL R5 actual=%0h expected=onehot0", owned_o);
    end
  end

  function automatic logic [N-1:0] lowest(input logic [N-1:0] p);
    return p & (~p + 1'b1);
  endfunction

  // from idle: request, win, hold, release; checks at negedges
  task automatic cycle_grant(input logic [N-1:0] pat);
    logic [N-1:0] exp_own;
    exp_own = lowest(pat);
    req_i = pat;
    @(negedge clk_i);
    chk("R2 grant", {31'd0, grant_o}, 32'd1);
    chk("R3 no owner yet", {28'd0, owned_o}, 32'd0);
    @(negedge clk_i);
    chk("R3 owner", {28'd0, owned_o}, {28'd0, exp_own});
    chk("R6 grant low", {31'd0, grant_o}, 32'd0);
    @(negedge clk_i);
    chk("R6 busy", {31'd0, busy_o}, 32'd1);
    release_i = 1'b1;
    @(negedge clk_i);
    release_i = 1'b0;
    req_i = '0;
    chk("R7 owner cleared", {28'd0, owned_o}, 32'd0);
    chk("R7 grant gap", {31'd0, grant_o}, 32'd0);
    chk("R7 busy low", {31'd0, busy_o}, 32'd0);
    @(negedge clk_i);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 grant", {31'd0, grant_o}, 32'd0);
    chk("R1 owned", {28'd0, owned_o}, 32'd0);
    chk("R1 busy", {31'd0, busy_o}, 32'd0);

    // R3 R4: every nonzero request pattern
    for (int p = 1; p < (1 << N); p++) cycle_grant(p[N-1:0]);

    // R8: release while idle
    release_i = 1'b1;
    @(negedge clk_i);
    release_i = 1'b0;
    chk("R8 idle release grant", {31'd0, grant_o}, 32'd0);
    chk("R8 idle release busy", {31'd0, busy_o}, 32'd0);

    // R8: release in the cycle an owner exists but not yet busy
    req_i = 4'b0100;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R8 owner present", {28'd0, owned_o}, 32'h4);
    release_i = 1'b1;
    @(negedge clk_i);
    release_i = 1'b0;
    chk("R8 owner kept", {28'd0, owned_o}, 32'h4);
    chk("R8 busy reached", {31'd0, busy_o}, 32'd1);

    // R11: owner drops request, keeps bus
    req_i = '0;
    repeat (3) begin
      @(negedge clk_i);
      chk("R11 hold", {28'd0, owned_o}, 32'h4);
      chk("R11 grant low", {31'd0, grant_o}, 32'd0);
    end
    release_i = 1'b1;
    @(negedge clk_i);
    release_i = 1'b0;
    chk("R7 cleared", {28'd0, owned_o}, 32'd0);
    @(negedge clk_i);

    // R9: withdraw while grant raised
    req_i = 4'b1000;
    @(negedge clk_i);
    chk("R9 grant up", {31'd0, grant_o}, 32'd1);
    req_i = '0;
    @(negedge clk_i);
    chk("R9 no owner", {28'd0, owned_o}, 32'd0);
    chk("R9 grant down", {31'd0, grant_o}, 32'd0);
    chk("R9 not busy", {31'd0, busy_o}, 32'd0);
    @(negedge clk_i);
    chk("R9 idle", {31'd0, grant_o}, 32'd0);

    // R10: device 0 keeps requesting, device 3 starves; R7 gap each time
    req_i = 4'b1001;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk_i);
      chk("R10 grant", {31'd0, grant_o}, 32'd1);
      @(negedge clk_i);
      chk("R10 owner is dev0", {28'd0, owned_o}, 32'h1);
      @(negedge clk_i);
      release_i = 1'b1;
      @(negedge clk_i);
      release_i = 1'b0;
      chk("R7 gap under load", {31'd0, grant_o}, 32'd0);
    end
    req_i = '0;
    repeat (3) @(negedge clk_i);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule